// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps one reservation on behalf of a single processor core: a reserved word address and a valid flag. A load-reserved request from the core records its word and arms the flag. A later store-conditional may write memory only while that flag is still armed. Two system buses are snooped in parallel. A write from any master other than the core that lands anywhere inside the reserved word drops the flag. On the next clock it also raises a cancel pulse so the core can discard its own copy of the reservation.

The core presents one request per cycle. The request carries a kind code, a byte address, and the termination status of its address and data phases. The block answers with a write enable for the memory path and, one cycle after each store-conditional, a done pulse with a success bit. Addresses are compared above the word offset, so the reservation covers one aligned 32-bit word. Any byte or half-word write into it counts as a hit.

Top module: `lrsc_monitor`

## Requirements
- R1: During reset and on the first cycle after it, the flag is clear and `resv_cancel`, `sc_done`, `sc_ok` and `mem_wr_en` are all 0.
- R2: A load-reserved request (kind 2'b10) records its word and arms the flag whatever its phase status: `core_ap_ok`=0 or `core_dp_err`=1 still arms it.
- R3: A store-conditional (kind 2'b11) with the flag armed, no conflicting snoop hit and `core_ap_ok`=1 drives `mem_wr_en`=1 in the same cycle. In the next cycle it gives `sc_done`=1, and `sc_ok`=1 when `core_dp_err` was 0.
- R4: A store-conditional whose address phase ends normally disarms the flag even when `core_dp_err`=1; in that case `sc_ok` is 0 while the write was still issued.
- R5: A store-conditional with `core_ap_ok`=0 issues no write, reports failure and leaves the flag armed.
- R6: An ordinary store from the core (kind 2'b01) always gets `mem_wr_en`=1 and never changes the flag, also when the same write shows up on a snooped bus with `snp_by_other`=0.
- R7: A snooped write with `snp_by_other`=1 on either bus whose address matches the reserved word on bits [31:2] disarms the flag; a write to a neighbouring word does not.
- R8: `resv_cancel` is 1 for exactly the one cycle after such a hit on an armed reservation, and 0 otherwise.
- R9: A store-conditional presented while the flag is clear issues no write and reports `sc_done`=1 with `sc_ok`=0.
- R10: When a foreign hit and the core's store-conditional arrive in the same cycle, the hit wins: no write, failure status, and a cancel pulse on the next cycle.
- R11: A new load-reserved request replaces the previous word, so a foreign write to the old word no longer disarms the flag.
- R12: A load-reserved request in the same cycle as a foreign hit on the old word keeps the new reservation armed and raises no cancel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core request present this cycle |
| core_req_kind | input | 2 | 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| core_req_addr | input | ADDR_W | Byte address of the core request |
| core_ap_ok | input | 1 | Address phase of the request ended normally |
| core_dp_err | input | 1 | Data phase of the request ended with an error |
| snp_wr_valid | input | NUM_BUSES | A write is seen on each snooped bus |
| snp_by_other | input | NUM_BUSES | That write comes from a master other than the core |
| snp_addr | input | NUM_BUSES x ADDR_W | Byte address of each snooped write |
| mem_wr_en | output | 1 | Let the core's write proceed to memory |
| sc_done | output | 1 | Pulse one cycle after a store-conditional |
| sc_ok | output | 1 | Store-conditional succeeded (valid with sc_done) |
| resv_cancel | output | 1 | Reservation lost to a foreign write last cycle |

## Verification
The bench builds the block with its defaults: a 32-bit address, a two-bit word offset and two snooped buses. With two buses, hits can be placed on either bus, alone or in the same cycle as a store-conditional or a new load-reserved request. The two-bit offset lets byte and half-word writes at offsets 2 and 3 land inside the reserved word, while offset 4 lands in the next word.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        RK_LOAD      = 2'b00,
        RK_STORE     = 2'b01,
        RK_LOAD_RSV  = 2'b10,
        RK_STORE_CND = 2'b11
    } req_kind_e;

    typedef struct packed {
        logic lr;
        logic sc;
        logic st;
        logic ap_ok;
        logic dp_err;
    } req_dec_t;

    typedef struct packed {
        logic done;
        logic ok;
    } sc_result_t;

    function automatic req_dec_t decode_req(input logic valid,
                                            input logic [1:0] kind,
                                            input logic ap_ok,
                                            input logic dp_err);
        req_dec_t d;
        d.lr     = valid && (kind == RK_LOAD_RSV);
        d.sc     = valid && (kind == RK_STORE_CND);
        d.st     = valid && (kind == RK_STORE);
        d.ap_ok  = ap_ok;
        d.dp_err = dp_err;
        return d;
    endfunction

endpackage

// File: rtl/lrsc_snoop_match.sv
module lrsc_snoop_match #(
    parameter int ADDR_W    = 32,
    parameter int NUM_BUSES = 2,
    parameter int WORD_LSB  = 2,
    localparam int TAG_W    = ADDR_W - WORD_LSB
) (
    input  logic [NUM_BUSES-1:0]             snp_wr_valid,
    input  logic [NUM_BUSES-1:0]             snp_by_other,
    input  logic [NUM_BUSES-1:0][ADDR_W-1:0] snp_addr,
    input  logic [TAG_W-1:0]                 resv_tag,
    input  logic                             resv_valid,
    output logic                             hit
);
    logic [NUM_BUSES-1:0] bus_hit;
    logic [NUM_BUSES-1:0] unused_offset;

    for (genvar b = 0; b < NUM_BUSES; b++) begin : g_bus
        assign bus_hit[b] = snp_wr_valid[b] && snp_by_other[b]
                         && (snp_addr[b][ADDR_W-1:WORD_LSB] == resv_tag);
        assign unused_offset[b] = ^snp_addr[b][WORD_LSB-1:0];
    end

    assign hit = resv_valid && (|bus_hit);
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg
    import lrsc_pkg::*;
#(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  req_dec_t         dec,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             hit,
    output logic [TAG_W-1:0] resv_tag,
    output logic             resv_valid,
    output logic             cancel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resv_tag   <= '0;
            resv_valid <= 1'b0;
            cancel     <= 1'b0;
        end else begin
            cancel <= hit && !dec.lr;
            if (dec.lr) begin
                resv_tag   <= req_tag;
                resv_valid <= 1'b1;
            end else if ((dec.sc && dec.ap_ok) || hit) begin
                resv_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lrsc_sc_gate.sv
module lrsc_sc_gate
    import lrsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  req_dec_t   dec,
    input  logic       resv_valid,
    input  logic       hit,
    output logic       mem_wr_en,
    output sc_result_t result
);
    logic sc_pass;

    always_comb begin
        sc_pass   = dec.sc && resv_valid && !hit && dec.ap_ok;
        mem_wr_en = dec.st || sc_pass;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else begin
            result.done <= dec.sc;
            result.ok   <= sc_pass && !dec.dp_err;
        end
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_BUSES = 2,
    parameter int WORD_LSB  = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             core_req_valid,
    input  logic [1:0]                       core_req_kind,
    input  logic [ADDR_W-1:0]                core_req_addr,
    input  logic                             core_ap_ok,
    input  logic                             core_dp_err,
    input  logic [NUM_BUSES-1:0]             snp_wr_valid,
    input  logic [NUM_BUSES-1:0]             snp_by_other,
    input  logic [NUM_BUSES-1:0][ADDR_W-1:0] snp_addr,
    output logic                             mem_wr_en,
    output logic                             sc_done,
    output logic                             sc_ok,
    output logic                             resv_cancel
);
    localparam int TAG_W = ADDR_W - WORD_LSB;

    req_dec_t   dec;
    sc_result_t result;
    logic [TAG_W-1:0] resv_tag;
    logic             resv_valid;
    logic             hit;
    logic             unused_req_offset;

    assign dec = decode_req(core_req_valid, core_req_kind, core_ap_ok, core_dp_err);
    assign unused_req_offset = ^core_req_addr[WORD_LSB-1:0];

    lrsc_snoop_match #(
        .ADDR_W   (ADDR_W),
        .NUM_BUSES(NUM_BUSES),
        .WORD_LSB (WORD_LSB)
    ) u_match (
        .snp_wr_valid(snp_wr_valid),
        .snp_by_other(snp_by_other),
        .snp_addr    (snp_addr),
        .resv_tag    (resv_tag),
        .resv_valid  (resv_valid),
        .hit         (hit)
    );

    lrsc_resv_reg #(
        .TAG_W(TAG_W)
    ) u_resv (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .req_tag   (core_req_addr[ADDR_W-1:WORD_LSB]),
        .hit       (hit),
        .resv_tag  (resv_tag),
        .resv_valid(resv_valid),
        .cancel    (resv_cancel)
    );

    lrsc_sc_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .resv_valid(resv_valid),
        .hit       (hit),
        .mem_wr_en (mem_wr_en),
        .result    (result)
    );

    assign sc_done = result.done;
    assign sc_ok   = result.ok;
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int ADDR_W    = 32,
    parameter int NUM_BUSES = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             core_req_valid,
    input logic [1:0]                       core_req_kind,
    input logic [NUM_BUSES-1:0]             snp_wr_valid,
    input logic [NUM_BUSES-1:0]             snp_by_other,
    input logic                             mem_wr_en,
    input logic                             sc_done,
    input logic                             sc_ok,
    input logic                             resv_cancel
);
    logic sc_req;
    logic st_req;
    logic foreign_wr;

    assign sc_req     = core_req_valid && (core_req_kind == 2'b11);
    assign st_req     = core_req_valid && (core_req_kind == 2'b01);
    assign foreign_wr = |(snp_wr_valid & snp_by_other);

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!resv_cancel && !sc_done && !sc_ok));

    p_done_follows_sc_r3: assert property (@(posedge clk) disable iff (rst)
        sc_req |=> sc_done);

    p_no_spurious_done_r3: assert property (@(posedge clk) disable iff (rst)
        !sc_req |=> !sc_done);

    p_ok_within_done_r4: assert property (@(posedge clk) disable iff (rst)
        sc_ok |-> sc_done);

    p_plain_store_passes_r6: assert property (@(posedge clk) disable iff (rst)
        st_req |-> mem_wr_en);

    p_cancel_blocks_sc_r7: assert property (@(posedge clk) disable iff (rst)
        (resv_cancel && sc_req) |-> !mem_wr_en);

    p_cancel_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
        resv_cancel |-> $past(foreign_wr));

    p_write_needs_store_r9: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (st_req || sc_req));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_BUSES(NUM_BUSES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .core_req_valid(core_req_valid),
    .core_req_kind (core_req_kind),
    .snp_wr_valid  (snp_wr_valid),
    .snp_by_other  (snp_by_other),
    .mem_wr_en     (mem_wr_en),
    .sc_done       (sc_done),
    .sc_ok         (sc_ok),
    .resv_cancel   (resv_cancel)
);

// File: tb/tb_lrsc_monitor.sv
`timescale 1ns/1ps
module tb_lrsc_monitor;
    localparam int AW = 32;
    localparam int NB = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              core_req_valid = 1'b0;
    logic [1:0]        core_req_kind = 2'b00;
    logic [AW-1:0]     core_req_addr = '0;
    logic              core_ap_ok = 1'b0;
    logic              core_dp_err = 1'b0;
    logic [NB-1:0]     snp_wr_valid = '0;
    logic [NB-1:0]     snp_by_other = '0;
    logic [NB-1:0][AW-1:0] snp_addr = '0;
    logic              mem_wr_en, sc_done, sc_ok, resv_cancel;

    always #2 clk = ~clk;

    lrsc_monitor #(.ADDR_W(AW), .NUM_BUSES(NB), .WORD_LSB(2)) dut (
        .clk(clk), .rst(rst),
        .core_req_valid(core_req_valid), .core_req_kind(core_req_kind),
        .core_req_addr(core_req_addr), .core_ap_ok(core_ap_ok),
        .core_dp_err(core_dp_err), .snp_wr_valid(snp_wr_valid),
        .snp_by_other(snp_by_other), .snp_addr(snp_addr),
        .mem_wr_en(mem_wr_en), .sc_done(sc_done), .sc_ok(sc_ok),
        .resv_cancel(resv_cancel)
    );

    typedef struct {
        bit    done;
        bit    ok;
        bit    cancel;
        string tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit summary_done = 0;

    bit          m_flag = 0;
    logic [31:0] m_addr = '0;

    localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LR = 2'b10, K_SC = 2'b11;
    localparam logic [31:0] A = 32'h1000_0040;
    localparam logic [31:0] B = 32'h2000_0100;

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!summary_done) begin
            summary_done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    endtask

    // driver: one core request plus up to two snooped writes per cycle
    task automatic step(string tag, bit v, logic [1:0] k, logic [31:0] a,
                        bit apok, bit dperr,
                        bit s0v, bit s0o, logic [31:0] s0a,
                        bit s1v, bit s1o, logic [31:0] s1a);
        bit hit, lr, sc, st, pass;
        exp_t it;
        @(negedge clk);
        core_req_valid = v; core_req_kind = k; core_req_addr = a;
        core_ap_ok = apok; core_dp_err = dperr;
        snp_wr_valid = {s1v, s0v}; snp_by_other = {s1o, s0o};
        snp_addr[0] = s0a; snp_addr[1] = s1a;
        hit = m_flag && ((s0v && s0o && s0a[31:2] == m_addr[31:2]) ||
                         (s1v && s1o && s1a[31:2] == m_addr[31:2]));
        lr = v && k == K_LR;
        sc = v && k == K_SC;
        st = v && k == K_ST;
        pass = sc && m_flag && !hit && apok;
        #1;
        check(tag, "mem_wr_en", int'(mem_wr_en), int'(st || pass));
        it.done = sc; it.ok = pass && !dperr; it.cancel = hit && !lr; it.tag = tag;
        q.push_back(it);
        if (lr) begin
            m_addr = a; m_flag = 1;
        end else if ((sc && apok) || hit) begin
            m_flag = 0;
        end
    endtask

    task automatic req(string tag, logic [1:0] k, logic [31:0] a, bit apok, bit dperr);
        step(tag, 1, k, a, apok, dperr, 0, 0, '0, 0, 0, '0);
    endtask

    task automatic idle(string tag);
        step(tag, 0, K_LD, '0, 0, 0, 0, 0, '0, 0, 0, '0);
    endtask

    // monitor: pops one expected item per cycle after the registers update
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check(it.tag, "sc_done", int'(sc_done), int'(it.done));
                if (it.done) check(it.tag, "sc_ok", int'(sc_ok), int'(it.ok));
                check(it.tag, "resv_cancel", int'(resv_cancel), int'(it.cancel));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "resv_cancel", int'(resv_cancel), 0);
        check("R1", "sc_done", int'(sc_done), 0);
        check("R1", "sc_ok", int'(sc_ok), 0);
        check("R1", "mem_wr_en", int'(mem_wr_en), 0);
        rst = 0;

        req("R9", K_SC, A, 1, 0);
        req("R2", K_LR, A, 0, 1);
        req("R3", K_SC, A, 1, 0);
        req("R4", K_SC, A, 1, 0);

        req("R4", K_LR, A, 1, 0);
        req("R4", K_SC, A, 1, 1);
        req("R4", K_SC, A, 1, 0);

        req("R5", K_LR, A, 1, 0);
        req("R5", K_SC, A, 0, 0);
        req("R5", K_SC, A, 1, 0);

        req("R6", K_LR, A, 1, 0);
        step("R6", 1, K_ST, A, 1, 0, 1, 0, A, 0, 0, '0);
        req("R6", K_LD, A, 1, 0);
        req("R6", K_SC, A, 1, 0);

        req("R7", K_LR, A, 1, 0);
        step("R7", 0, K_LD, '0, 0, 0, 0, 0, '0, 1, 1, A + 3);
        req("R7", K_SC, A, 1, 0);

        req("R7", K_LR, A, 1, 0);
        step("R7", 0, K_LD, '0, 0, 0, 1, 1, A + 4, 0, 0, '0);
        req("R7", K_SC, A, 1, 0);

        req("R8", K_LR, A, 1, 0);
        step("R8", 0, K_LD, '0, 0, 0, 1, 1, A + 2, 0, 0, '0);
        step("R8", 0, K_LD, '0, 0, 0, 1, 1, A + 2, 0, 0, '0);
        idle("R8");

        req("R10", K_LR, A, 1, 0);
        step("R10", 1, K_SC, A, 1, 0, 0, 0, '0, 1, 1, A);
        idle("R10");

        req("R11", K_LR, A, 1, 0);
        req("R11", K_LR, B, 1, 0);
        step("R11", 0, K_LD, '0, 0, 0, 1, 1, A, 0, 0, '0);
        req("R11", K_SC, B, 1, 0);

        req("R12", K_LR, A, 1, 0);
        step("R12", 1, K_LR, B, 1, 0, 1, 1, A, 1, 1, A + 1);
        req("R12", K_SC, B, 1, 0);

        idle("end");
        idle("end");
        @(negedge clk);
        check("end", "queue_left", q.size(), 0);
        report();
    end
endmodule